// File: doc/BRIEF.md
# Write-Only Serial Configuration Receiver

This block is a receive-only slave on a two-wire open-drain bus made of a clock line and a data line. It runs from a fast system clock. Both bus lines pass through a synchronizer and then a majority filter. Start and stop conditions and the bus clock edges are found on the filtered lines. A transfer opens with a fixed address byte. Two placeholder bytes follow. After them come up to seven configuration bytes, which land in a register file whose contents leave the block continuously on a flat output vector.

An acknowledge is produced by asserting an open-drain pull enable for one bus clock after each accepted byte. A register bit is written at the moment its bus clock period completes, so a master may stop or restart at any point and leave the remaining registers untouched. The register file resets to a fixed set of defaults: output-enable bits read 1 and the reserved and mode bits read 0.

Top module: `cfg_serial_rx`

## Requirements
- R1: The address byte must equal 0xD2 (seven-bit address 0x69 with a write bit of 0). On a match the byte is acknowledged. On any other value there is no acknowledge and no register change, and the bus is ignored until the next start condition.
- R2: The two bytes after the address are acknowledged, and their contents change no register.
- R3: Configuration bytes 0 to 6 follow the two placeholder bytes in that order, each sent MSB first. Byte k appears on `cfg_o[8k+7:8k]`.
- R4: A falling data line while the clock is high is a start, and a rising data line while the clock is high is a stop. A repeated start begins a new transfer at the address byte.
- R5: `sda_pull_o` rises on the clock falling edge that ends the eighth bit of an accepted byte and falls on the next clock falling edge. It is low at all other times.
- R6: Each register bit takes its new value when the falling clock edge closes that bit. Earlier bits of a byte are visible before the byte completes.
- R7: A stop or a repeated start ends a transfer. Registers not yet reached keep their values, and a bit whose clock never falls is not written.
- R8: After reset, bytes 0 to 6 read 0x00, 0xCF, 0x7F, 0xFF, 0x0F, 0x13 and 0x00, and `sda_pull_o` is 0.
- R9: A pulse on either line that lasts three or fewer system clocks (60 ns at 50 MHz) has no effect.
- R10: A byte after configuration byte 6 is not acknowledged and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| cfg_o | output | NREG*8 | Register file contents, byte k at bits 8k+7:8k |

## Verification
The bench builds the block with its default parameters: seven registers, a two-stage synchronizer and a seven-sample majority window. With these values the full ten-byte write and the eleventh, overflow byte can be reached in a few thousand cycles. Three-cycle glitches sit just inside the rejection limit. The bus quarter period is 25 system clocks, well above the filter delay, so every acknowledge and every committed bit can be sampled at fixed points in the bit period.

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx #(
  parameter logic [7:0] DEV_ADDR = 8'hD2,
  parameter int NREG = 7,
  parameter int SYNC = 2,
  parameter int FILT = 7,
  parameter logic [NREG*8-1:0] RST_VAL = 56'h00_13_0F_FF_7F_CF_00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_pull_o,
  output logic [NREG*8-1:0] cfg_o
);
  localparam int IW = $clog2(NREG + 4);
  localparam int RW = $clog2(NREG);
  localparam logic [IW-1:0] FIRST_D = IW'(3);
  localparam logic [IW-1:0] END_D = IW'(3 + NREG);

  logic [SYNC-1:0] scl_sy, sda_sy;
  logic [FILT-1:0] scl_w, sda_w;
  logic scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1;
      scl_w  <= '1; sda_w  <= '1;
      scl_f  <= 1'b1; sda_f <= 1'b1;
      scl_p  <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC-2:0], sda_i};
      scl_w  <= {scl_w[FILT-2:0], scl_sy[SYNC-1]};
      sda_w  <= {sda_w[FILT-2:0], sda_sy[SYNC-1]};
      scl_f  <= $countones(scl_w) > FILT / 2;
      sda_f  <= $countones(sda_w) > FILT / 2;
      scl_p  <= scl_f;
      sda_p  <= sda_f;
    end
  end

  wire start_c = scl_f & scl_p & sda_p & ~sda_f;
  wire stop_c  = scl_f & scl_p & ~sda_p & sda_f;
  wire rise    = scl_f & ~scl_p;
  wire fall    = ~scl_f & scl_p;

  logic active, in_ack, got, smp;
  logic [2:0] bitc;
  logic [IW-1:0] idx;
  logic [6:0] shf;
  logic [7:0] regs [NREG];

  wire [7:0]    nbyte = {shf, smp};
  wire          wr_en = (idx >= FIRST_D) && (idx < END_D);
  wire [RW-1:0] didx  = RW'(idx - FIRST_D);
  wire          take  = (idx == '0) ? (nbyte == DEV_ADDR) : (idx < END_D);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; in_ack <= 1'b0; got <= 1'b0; smp <= 1'b0;
      bitc <= '0; idx <= '0; shf <= '0; sda_pull_o <= 1'b0;
      for (int k = 0; k < NREG; k++) regs[k] <= RST_VAL[k*8 +: 8];
    end else if (start_c) begin
      active <= 1'b1; in_ack <= 1'b0; got <= 1'b0;
      bitc <= '0; idx <= '0; sda_pull_o <= 1'b0;
    end else if (stop_c) begin
      active <= 1'b0; in_ack <= 1'b0; got <= 1'b0; sda_pull_o <= 1'b0;
    end else if (active) begin
      if (rise && !in_ack) begin
        smp <= sda_f;
        got <= 1'b1;
      end else if (fall && in_ack) begin
        in_ack <= 1'b0;
        sda_pull_o <= 1'b0;
      end else if (fall && got) begin
        got <= 1'b0;
        shf <= nbyte[6:0];
        if (wr_en) regs[didx][~bitc] <= smp;
        if (bitc == 3'd7) begin
          bitc <= '0;
          if (take) begin
            in_ack <= 1'b1;
            sda_pull_o <= 1'b1;
            idx <= idx + IW'(1);
          end else begin
            active <= 1'b0;
          end
        end else begin
          bitc <= bitc + 3'd1;
        end
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign cfg_o[g*8 +: 8] = regs[g];
  end

  AST_PULL_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && scl_p) |-> $stable(sda_pull_o)); // R5
  AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (idx == '0 && bitc == '0 && !sda_pull_o)); // R4
  AST_IDLE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sda_pull_o); // R1
  AST_SKIP_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && active && got && !in_ack && idx < FIRST_D) |=> $stable(cfg_o)); // R2
  AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cfg_o ^ $past(cfg_o)) <= 1); // R6
  AST_NO_WRITE_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (idx >= END_D) |=> $stable(cfg_o)); // R10
endmodule

// File: tb/sim_cfg_serial_rx.sv
module sim_cfg_serial_rx;
  localparam int Q = 25;
  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic pull;
  logic [55:0] cfg;
  wire sda_line = m_sda & ~pull;
  int total = 0, bad = 0;
  logic [7:0] mdl [7];

  always #10 clk = ~clk;

  cfg_serial_rx u0 (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
                    .sda_pull_o(pull), .cfg_o(cfg));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [55:0] pack();
    logic [55:0] v;
    for (int k = 0; k < 7; k++) v[k*8 +: 8] = mdl[k];
    return v;
  endfunction

  task automatic chk_regs(input string tag);
    chk(cfg === pack(), tag, {8'h0, cfg}, {8'h0, pack()});
  endtask

  task automatic start_c();
    m_sda = 1; tick(Q); m_scl = 1; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q);
  endtask

  task automatic stop_c();
    m_sda = 0; tick(Q); m_scl = 1; tick(Q); m_sda = 1; tick(Q);
  endtask

  task automatic put_bit(input logic b, input logic glitch);
    m_sda = b; tick(Q);
    if (glitch && !b) begin m_scl = 1; tick(3); m_scl = 0; tick(Q); end
    m_scl = 1; tick(Q / 2);
    if (glitch && b) begin m_sda = 0; tick(3); m_sda = 1; end
    if (pull) chk(1'b0, "R5 pull during data bit", 1, 0);
    tick(Q - Q / 2); m_scl = 0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic glitch, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i], glitch);
    m_sda = 1; tick(Q); m_scl = 1; tick(Q / 2);
    ack = ~sda_line;
    tick(Q - Q / 2); m_scl = 0; tick(Q);
    chk(pull == 1'b0, "R5 pull released after ack", pull, 0);
  endtask

  task automatic head(input logic [7:0] addr, output logic a0);
    logic a1, a2;
    start_c();
    send_byte(addr, 0, a0);
    send_byte(8'hA5, 0, a1);
    send_byte(8'h3C, 0, a2);
    if (a0) begin
      chk(a1 && a2, "R2 placeholder bytes acked", {a1, a2}, 2'b11);
      chk_regs("R2 placeholder bytes ignored");
    end
  endtask

  task automatic t_reset();
    mdl = '{8'h00, 8'hCF, 8'h7F, 8'hFF, 8'h0F, 8'h13, 8'h00};
    chk_regs("R8 reset values");
    chk(pull == 0, "R8 pull idle", pull, 0);
  endtask

  task automatic t_full();
    logic a;
    logic [7:0] d [7] = '{8'h81, 8'h42, 8'h24, 8'h18, 8'hF0, 8'h0F, 8'h5A};
    head(8'hD2, a);
    chk(a, "R1 address ack", a, 1);
    for (int k = 0; k < 7; k++) begin
      send_byte(d[k], 0, a);
      mdl[k] = d[k];
      chk(a, "R3 data ack", a, 1);
    end
    stop_c();
    chk_regs("R3 full write");
  endtask

  task automatic t_bad_addr();
    logic a;
    start_c();
    send_byte(8'hD4, 0, a);
    chk(!a, "R1 wrong address no ack", a, 0);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'h00, 0, a);
      chk(!a, "R1 ignored until start", a, 0);
    end
    stop_c();
    chk_regs("R1 wrong address no change");
    start_c();
    send_byte(8'hD3, 0, a);
    chk(!a, "R1 read bit rejected", a, 0);
    stop_c();
  endtask

  task automatic t_trunc();
    logic a;
    head(8'hD2, a);
    send_byte(8'h11, 0, a);
    mdl[0] = 8'h11;
    stop_c();
    chk_regs("R7 stop after first data byte");
  endtask

  task automatic t_bitwise();
    logic a;
    head(8'hD2, a);
    put_bit(1, 0); put_bit(0, 0); put_bit(1, 0); put_bit(0, 0);
    mdl[0] = {4'b1010, mdl[0][3:0]};
    chk_regs("R6 partial byte visible");
    stop_c();
    chk_regs("R7 stop mid byte keeps rest");
  endtask

  task automatic t_restart();
    logic a;
    head(8'hD2, a);
    send_byte(8'h77, 0, a);
    mdl[0] = 8'h77;
    head(8'hD2, a);
    chk(a, "R4 repeated start address ack", a, 1);
    send_byte(8'h88, 0, a);
    send_byte(8'h99, 0, a);
    mdl[0] = 8'h88; mdl[1] = 8'h99;
    stop_c();
    chk_regs("R4 repeated start restarts at address");
  endtask

  task automatic t_glitch();
    logic a;
    head(8'hD2, a);
    send_byte(8'hC6, 1, a);
    chk(a, "R9 glitched byte acked", a, 1);
    mdl[0] = 8'hC6;
    send_byte(8'h3B, 1, a);
    mdl[1] = 8'h3B;
    stop_c();
    chk_regs("R9 short pulses rejected");
  endtask

  task automatic t_overflow();
    logic a;
    head(8'hD2, a);
    for (int k = 0; k < 7; k++) begin
      send_byte(8'(8'h30 + k), 0, a);
      mdl[k] = 8'(8'h30 + k);
    end
    send_byte(8'hEE, 0, a);
    chk(!a, "R10 extra byte no ack", a, 0);
    stop_c();
    chk_regs("R10 extra byte no change");
  endtask

  initial begin
    tick(5);
    rst_n = 1;
    tick(20);
    t_reset();
    t_full();
    t_bad_addr();
    t_trunc();
    t_bitwise();
    t_restart();
    t_glitch();
    t_overflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule